// File: doc/BRIEF.md
# Savings-Scored Coprocessor Slot Arbiter

This block decides which software tasks own a small pool of reconfigurable coprocessor slots. Each of `N_TASKS` tasks reports, when a job ends, how many cycles a hardware implementation saved or would have saved. The arbiter keeps a bounded score per task and renormalises all scores after every report. It moves a slot to a new task only when the new task has clearly pulled ahead. Loading a slot is expensive, so the arbiter uses a programmable gap threshold as hysteresis.

When the arbiter moves a slot, it raises a per-slot reconfiguration request that names the target task. The request stays up until the loader reports completion. A task that asks for access is granted it only when it owns a slot whose load has finished. Otherwise the task keeps running in software.

Top module: `coproc_own_arb`

## Requirements
- R1: A completion strobe on task i adds the presented savings value to task i's score. This happens whether or not task i owns a slot.
- R2: No score ever exceeds twice the `thresh` input. A sum above that bound is clipped to the bound.
- R3: After each score update, an offset x is subtracted from every score, and no score goes below zero. x is the smallest nonzero score among the tasks that are not in the top `N_SLOTS` of the updated ranking, or zero when there is no such score.
- R4: Tasks are ranked by score from highest to lowest, and equal scores rank the lower task index first. Only tasks of rank below `N_SLOTS` may win a slot.
- R5: The candidate is the best-ranked eligible task that owns no slot. The victim is the lowest-index empty slot, or the slot whose owner ranks worst when no slot is empty. An empty victim counts as score 0. A reconfiguration starts only when the candidate's score exceeds the victim's score by strictly more than `thresh`.
- R6: If the victim's owner has its busy flag high, the move is skipped. It is taken on the first cycle after busy falls, if the condition of R5 still holds then.
- R7: `acc_gnt[i]` is high only while `acc_req[i]` is high and task i owns a slot that has finished loading. A task loses its grant in the cycle after its slot is moved.
- R8: While a slot is loading, its new owner gets no grant. The grant can appear in the cycle after `rcfg_done` for that slot.
- R9: Ownership moves when the request is issued. `rcfg_req[s]` then stays high with `rcfg_task` field s stable until `rcfg_done[s]`, so at most one load is outstanding per slot. The task index for slot s sits in bits [s*TIDX_W +: TIDX_W].
- R10: Completions from several tasks in the same cycle are queued. They are applied one per cycle in ascending task index, each with its own renormalisation. A completion captured at one edge updates the score at the next edge, and the ownership decision based on it is registered one edge later.
- R11: After reset no slot has an owner, all scores are zero, and no request or grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | THR_W | Reconfiguration gap threshold; scores are bounded at twice this |
| done_vld | input | N_TASKS | Per-task job completion strobe |
| done_sav | input | N_TASKS*SAV_W | Per-task savings value, task i in bits [i*SAV_W +: SAV_W] |
| busy | input | N_TASKS | Per-task flag: task is using its slot now |
| acc_req | input | N_TASKS | Per-task request to use a coprocessor |
| acc_gnt | output | N_TASKS | Per-task coprocessor access grant |
| rcfg_req | output | N_SLOTS | Per-slot reconfiguration request, held until done |
| rcfg_task | output | N_SLOTS*TIDX_W | Target task index per slot |
| rcfg_done | input | N_SLOTS | Per-slot load completion pulse |

## Verification
Scores are never visible at the ports. A corrupted score, a wrong rank or a wrong offset therefore shows up only as a reconfiguration request that comes early, late, never, or names the wrong task. It usually appears within three cycles of the completion that exposes it. The bench therefore replays a cycle-accurate arithmetic model of the scores and compares every request, target and grant on every cycle. It also builds directed sequences in which one wrong saturation, tie order, offset or processing order flips the outcome of a later decision. A fault in the slot states shows up at once as a grant during loading, or as a grant that is missing after done.

// File: rtl/coarb_pkg.sv
`timescale 1ns/1ps
package coarb_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADING = 2'd1,
    SLOT_READY   = 2'd2
  } slot_st_e;
endpackage

// File: rtl/coarb_rank.sv
`timescale 1ns/1ps
// Ranks a score vector: rank 0 is the highest score, ties go to the lower index.
module coarb_rank #(
  parameter int N_TASKS = 4,
  parameter int W       = 16,
  localparam int TIDX_W = $clog2(N_TASKS)
) (
  input  logic [N_TASKS-1:0][W-1:0]      vals,
  output logic [N_TASKS-1:0][TIDX_W-1:0] rank
);
  always_comb begin
    for (int i = 0; i < N_TASKS; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N_TASKS; j++) begin
        if (j != i && ((vals[j] > vals[i]) || (vals[j] == vals[i] && j < i)))
          cnt++;
      end
      rank[i] = TIDX_W'(cnt);
    end
  end
endmodule

// File: rtl/coarb_score_bank.sv
`timescale 1ns/1ps
// Queues completions, applies one per cycle, clips and renormalises scores.
module coarb_score_bank #(
  parameter int N_TASKS = 4,
  parameter int N_SLOTS = 2,
  parameter int SAV_W   = 12,
  parameter int THR_W   = 15,
  localparam int SCORE_W = THR_W + 1,
  localparam int TIDX_W  = $clog2(N_TASKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [THR_W-1:0]                  thresh,
  input  logic [N_TASKS-1:0]                done_vld,
  input  logic [N_TASKS-1:0][SAV_W-1:0]     done_sav,
  output logic [N_TASKS-1:0][SCORE_W-1:0]   score_q,
  output logic [N_TASKS-1:0]                upd_mask,
  output logic [SCORE_W-1:0]                renorm_x
);
  logic [N_TASKS-1:0]               pend_q;
  logic [N_TASKS-1:0][SAV_W-1:0]    sav_q;
  logic [N_TASKS-1:0][SCORE_W-1:0]  added;
  logic [N_TASKS-1:0][SCORE_W-1:0]  score_n;
  logic [N_TASKS-1:0][TIDX_W-1:0]   post_rank;

  function automatic logic [SCORE_W-1:0] sat_add(input logic [SCORE_W-1:0] s,
                                                 input logic [SAV_W-1:0]   v,
                                                 input logic [THR_W-1:0]   t);
    logic [SCORE_W:0] sum;
    logic [SCORE_W:0] cap;
    sum = {1'b0, s} + {{(SCORE_W + 1 - SAV_W){1'b0}}, v};
    cap = {1'b0, t, 1'b0};
    return (sum > cap) ? cap[SCORE_W-1:0] : sum[SCORE_W-1:0];
  endfunction

  function automatic logic [SCORE_W-1:0] floor_sub(input logic [SCORE_W-1:0] s,
                                                   input logic [SCORE_W-1:0] x);
    return (s > x) ? (s - x) : '0;
  endfunction

  // lowest pending index wins this cycle
  always_comb begin
    logic found;
    found    = 1'b0;
    upd_mask = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (pend_q[i] && !found) begin
        upd_mask[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_TASKS; i++)
      added[i] = upd_mask[i] ? sat_add(score_q[i], sav_q[i], thresh) : score_q[i];
  end

  coarb_rank #(.N_TASKS(N_TASKS), .W(SCORE_W)) u_post_rank (
    .vals (added),
    .rank (post_rank)
  );

  // offset: smallest nonzero score outside the top N_SLOTS
  always_comb begin
    renorm_x = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (int'(post_rank[i]) >= N_SLOTS && added[i] != '0 &&
          (renorm_x == '0 || added[i] < renorm_x))
        renorm_x = added[i];
    end
  end

  always_comb begin
    for (int i = 0; i < N_TASKS; i++)
      score_n[i] = (|upd_mask) ? floor_sub(added[i], renorm_x) : score_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      sav_q   <= '0;
      score_q <= '0;
    end else begin
      score_q <= score_n;
      pend_q  <= (pend_q & ~upd_mask) | done_vld;
      for (int i = 0; i < N_TASKS; i++)
        if (done_vld[i]) sav_q[i] <= done_sav[i];
    end
  end
endmodule

// File: rtl/coarb_slot_ctrl.sv
`timescale 1ns/1ps
// Picks candidate and victim, issues loads, tracks slot states and grants.
module coarb_slot_ctrl
  import coarb_pkg::*;
#(
  parameter int N_TASKS = 4,
  parameter int N_SLOTS = 2,
  parameter int THR_W   = 15,
  localparam int SCORE_W = THR_W + 1,
  localparam int TIDX_W  = $clog2(N_TASKS),
  localparam int SIDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [THR_W-1:0]                 thresh,
  input  logic [N_TASKS-1:0][SCORE_W-1:0]  score_q,
  input  logic [N_TASKS-1:0][TIDX_W-1:0]   rank,
  input  logic [N_TASKS-1:0]               busy,
  input  logic [N_TASKS-1:0]               acc_req,
  input  logic [N_SLOTS-1:0]               rcfg_done,
  output logic [N_TASKS-1:0]               acc_gnt,
  output logic [N_SLOTS-1:0]               rcfg_req,
  output logic [N_SLOTS-1:0][TIDX_W-1:0]   rcfg_task,
  output logic                             rc_fire,
  output logic [SIDX_W-1:0]                rc_slot
);
  slot_st_e                         st_q [N_SLOTS];
  logic [N_SLOTS-1:0][TIDX_W-1:0]   own_q;
  logic [N_TASKS-1:0]               owned;
  logic [N_TASKS-1:0]               ready;
  logic [N_SLOTS-1:0][TIDX_W-1:0]   own_rank;
  logic [N_SLOTS-1:0][SCORE_W-1:0]  own_score;
  logic [N_SLOTS-1:0]               own_busy;
  logic                             cand_ok;
  logic [TIDX_W-1:0]                cand_idx;
  logic [TIDX_W-1:0]                cand_rank;
  logic [SCORE_W-1:0]               cand_score;
  int                               v_slot;
  logic                             v_empty;
  logic [SCORE_W-1:0]               v_score;

  // per-slot view of its owner
  always_comb begin
    owned     = '0;
    ready     = '0;
    own_rank  = '0;
    own_score = '0;
    own_busy  = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      for (int i = 0; i < N_TASKS; i++) begin
        if (own_q[s] == TIDX_W'(i)) begin
          own_rank[s]  = rank[i];
          own_score[s] = score_q[i];
          own_busy[s]  = busy[i];
          if (st_q[s] != SLOT_EMPTY) owned[i] = 1'b1;
          if (st_q[s] == SLOT_READY) ready[i] = 1'b1;
        end
      end
    end
  end

  // best-ranked eligible non-owner
  always_comb begin
    cand_ok    = 1'b0;
    cand_idx   = '0;
    cand_rank  = '0;
    cand_score = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (int'(rank[i]) < N_SLOTS && !owned[i] && (!cand_ok || rank[i] < cand_rank)) begin
        cand_ok    = 1'b1;
        cand_idx   = TIDX_W'(i);
        cand_rank  = rank[i];
        cand_score = score_q[i];
      end
    end
  end

  // victim: first empty slot, else worst-ranked owner
  always_comb begin
    logic found;
    v_slot  = 0;
    v_empty = 1'b0;
    found   = 1'b0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (st_q[s] == SLOT_EMPTY) begin
        if (!v_empty) begin
          v_empty = 1'b1;
          v_slot  = s;
        end
      end else if (!v_empty && (!found || own_rank[s] > own_rank[v_slot])) begin
        found  = 1'b1;
        v_slot = s;
      end
    end
    v_score = v_empty ? '0 : own_score[v_slot];
  end

  always_comb begin
    rc_fire = cand_ok && (cand_score > v_score) &&
              ((cand_score - v_score) > {1'b0, thresh}) &&
              (st_q[v_slot] != SLOT_LOADING) &&
              !(!v_empty && own_busy[v_slot]);
    rc_slot = SIDX_W'(v_slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOTS; s++) st_q[s] <= SLOT_EMPTY;
      own_q <= '0;
    end else begin
      for (int s = 0; s < N_SLOTS; s++) begin
        if (st_q[s] == SLOT_LOADING && rcfg_done[s]) st_q[s] <= SLOT_READY;
        if (rc_fire && v_slot == s) begin
          st_q[s]  <= SLOT_LOADING;
          own_q[s] <= cand_idx;
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N_SLOTS; s++) rcfg_req[s] = (st_q[s] == SLOT_LOADING);
    rcfg_task = own_q;
    acc_gnt   = acc_req & ready;
  end
endmodule

// File: rtl/coproc_own_arb.sv
`timescale 1ns/1ps
module coproc_own_arb #(
  parameter int N_TASKS = 4,
  parameter int N_SLOTS = 2,
  parameter int SAV_W   = 12,
  parameter int THR_W   = 15,
  localparam int TIDX_W = $clog2(N_TASKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [THR_W-1:0]            thresh,
  input  logic [N_TASKS-1:0]          done_vld,
  input  logic [N_TASKS*SAV_W-1:0]    done_sav,
  input  logic [N_TASKS-1:0]          busy,
  input  logic [N_TASKS-1:0]          acc_req,
  output logic [N_TASKS-1:0]          acc_gnt,
  output logic [N_SLOTS-1:0]          rcfg_req,
  output logic [N_SLOTS*TIDX_W-1:0]   rcfg_task,
  input  logic [N_SLOTS-1:0]          rcfg_done
);
  localparam int SCORE_W = THR_W + 1;
  localparam int SIDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic [N_TASKS-1:0][SAV_W-1:0]    sav_arr;
  logic [N_TASKS-1:0][SCORE_W-1:0]  score_q;
  logic [N_TASKS-1:0][TIDX_W-1:0]   rank;
  logic [N_TASKS-1:0]               upd_mask;
  logic [SCORE_W-1:0]               renorm_x;
  logic [N_SLOTS-1:0][TIDX_W-1:0]   task_arr;
  logic                             rc_fire;
  logic [SIDX_W-1:0]                rc_slot;

  assign sav_arr   = done_sav;
  assign rcfg_task = task_arr;

  coarb_score_bank #(.N_TASKS(N_TASKS), .N_SLOTS(N_SLOTS), .SAV_W(SAV_W), .THR_W(THR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .thresh   (thresh),
    .done_vld (done_vld),
    .done_sav (sav_arr),
    .score_q  (score_q),
    .upd_mask (upd_mask),
    .renorm_x (renorm_x)
  );

  coarb_rank #(.N_TASKS(N_TASKS), .W(SCORE_W)) u_rank (
    .vals (score_q),
    .rank (rank)
  );

  coarb_slot_ctrl #(.N_TASKS(N_TASKS), .N_SLOTS(N_SLOTS), .THR_W(THR_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .thresh    (thresh),
    .score_q   (score_q),
    .rank      (rank),
    .busy      (busy),
    .acc_req   (acc_req),
    .rcfg_done (rcfg_done),
    .acc_gnt   (acc_gnt),
    .rcfg_req  (rcfg_req),
    .rcfg_task (task_arr),
    .rc_fire   (rc_fire),
    .rc_slot   (rc_slot)
  );
endmodule

// File: rtl/coarb_chk.sv
`timescale 1ns/1ps
module coarb_chk #(
  parameter int N_TASKS = 4,
  parameter int N_SLOTS = 2,
  parameter int THR_W   = 15,
  localparam int SCORE_W = THR_W + 1,
  localparam int TIDX_W  = $clog2(N_TASKS),
  localparam int SIDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [THR_W-1:0]                 thresh,
  input logic [N_TASKS-1:0][SCORE_W-1:0]  score_q,
  input logic [N_TASKS-1:0]               upd_mask,
  input logic [SCORE_W-1:0]               renorm_x,
  input logic                             fire,
  input logic [SIDX_W-1:0]                fire_slot,
  input logic [N_TASKS-1:0]               acc_req,
  input logic [N_TASKS-1:0]               acc_gnt,
  input logic [N_SLOTS-1:0]               rcfg_req,
  input logic [N_SLOTS-1:0][TIDX_W-1:0]   rcfg_task,
  input logic [N_SLOTS-1:0]               rcfg_done
);
  logic any_zero;
  always_comb begin
    any_zero = 1'b0;
    for (int i = 0; i < N_TASKS; i++) if (score_q[i] == '0) any_zero = 1'b1;
  end

  p_one_update_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_mask));

  p_renorm_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|upd_mask) && renorm_x != '0) |=> any_zero);

  p_fire_free_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !rcfg_req[fire_slot]);

  p_fire_raises_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rcfg_req[$past(fire_slot)]);

  for (genvar i = 0; i < N_TASKS; i++) begin : g_task
    p_score_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      score_q[i] <= {thresh, 1'b0});
    p_gnt_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_gnt[i] |-> acc_req[i]);
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      p_no_gnt_loading_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rcfg_req[s] && rcfg_task[s] == TIDX_W'(i)) |-> !acc_gnt[i]);
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_hold
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rcfg_req[s] && !rcfg_done[s]) |=> (rcfg_req[s] && $stable(rcfg_task[s])));
  end
endmodule

bind coproc_own_arb coarb_chk #(.N_TASKS(N_TASKS), .N_SLOTS(N_SLOTS), .THR_W(THR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .thresh    (thresh),
  .score_q   (score_q),
  .upd_mask  (upd_mask),
  .renorm_x  (renorm_x),
  .fire      (rc_fire),
  .fire_slot (rc_slot),
  .acc_req   (acc_req),
  .acc_gnt   (acc_gnt),
  .rcfg_req  (rcfg_req),
  .rcfg_task (task_arr),
  .rcfg_done (rcfg_done)
);

// File: tb/coproc_own_arb_test.sv
`timescale 1ns/1ps
module coproc_own_arb_test;
  localparam int N   = 3;
  localparam int M   = 1;
  localparam int SW  = 8;
  localparam int TW  = 7;
  localparam int IW  = $clog2(N);
  localparam int THR = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TW-1:0]   thresh = TW'(THR);
  logic [N-1:0]    done_vld = '0;
  logic [N*SW-1:0] done_sav = '0;
  logic [N-1:0]    busy = '0;
  logic [N-1:0]    acc_req = '1;
  logic [N-1:0]    acc_gnt;
  logic [M-1:0]    rcfg_req;
  logic [M*IW-1:0] rcfg_task;
  logic [M-1:0]    rcfg_done = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  coproc_own_arb #(.N_TASKS(N), .N_SLOTS(M), .SAV_W(SW), .THR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .done_vld(done_vld), .done_sav(done_sav),
    .busy(busy), .acc_req(acc_req), .acc_gnt(acc_gnt), .rcfg_req(rcfg_req),
    .rcfg_task(rcfg_task), .rcfg_done(rcfg_done));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- arithmetic model ----------------
  int ms [N];
  bit mp [N];
  int mv [N];
  int mown [M];
  int mst [M];   // 0 empty, 1 loading, 2 ready

  // ranks by repeated selection of the best remaining task
  function automatic void order_of(input int sc [N], output int rk [N]);
    bit used [N];
    for (int i = 0; i < N; i++) used[i] = 1'b0;
    for (int pos = 0; pos < N; pos++) begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && (best < 0 || sc[i] > sc[best])) best = i;
      used[best] = 1'b1;
      rk[best] = pos;
    end
  endfunction

  task automatic model_step();
    int rk [N];
    int rk2 [N];
    int ns [N];
    bit owned [N];
    int cand, vs, pk, x, vsc;
    bit vempty, fire;
    order_of(ms, rk);
    for (int i = 0; i < N; i++) owned[i] = 1'b0;
    for (int s = 0; s < M; s++) if (mst[s] != 0) owned[mown[s]] = 1'b1;
    cand = -1;
    for (int i = 0; i < N; i++)
      if (rk[i] < M && !owned[i] && (cand < 0 || rk[i] < rk[cand])) cand = i;
    vs = -1; vempty = 1'b0;
    for (int s = 0; s < M; s++) begin
      if (mst[s] == 0) begin
        if (!vempty) begin vempty = 1'b1; vs = s; end
      end else if (!vempty && (vs < 0 || rk[mown[s]] > rk[mown[vs]])) vs = s;
    end
    fire = 1'b0;
    if (cand >= 0 && vs >= 0) begin
      vsc = (mst[vs] == 0) ? 0 : ms[mown[vs]];
      if (ms[cand] - vsc > THR && mst[vs] != 1 && !(mst[vs] != 0 && busy[mown[vs]]))
        fire = 1'b1;
    end
    for (int s = 0; s < M; s++) if (mst[s] == 1 && rcfg_done[s]) mst[s] = 2;
    if (fire) begin mst[vs] = 1; mown[vs] = cand; end
    pk = -1;
    for (int i = 0; i < N; i++) if (mp[i] && pk < 0) pk = i;
    if (pk >= 0) begin
      ns = ms;
      ns[pk] = (ns[pk] + mv[pk] > 2 * THR) ? 2 * THR : ns[pk] + mv[pk];
      order_of(ns, rk2);
      x = 0;
      for (int i = 0; i < N; i++)
        if (rk2[i] >= M && ns[i] > 0 && (x == 0 || ns[i] < x)) x = ns[i];
      for (int i = 0; i < N; i++) ms[i] = (ns[i] > x) ? ns[i] - x : 0;
      mp[pk] = 1'b0;
    end
    for (int i = 0; i < N; i++)
      if (done_vld[i]) begin mp[i] = 1'b1; mv[i] = int'(done_sav[i*SW +: SW]); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin ms[i] = 0; mp[i] = 1'b0; mv[i] = 0; end
      for (int s = 0; s < M; s++) begin mown[s] = 0; mst[s] = 0; end
    end else model_step();
  end

  // per-cycle comparison against the model (R5 decisions, R9 targets, R7 grants)
  always @(negedge clk) begin
    #1;
    if (model_on && !finished) begin
      for (int s = 0; s < M; s++) begin
        check(rcfg_req[s] == (mst[s] == 1), "R5 request vs model", int'(rcfg_req[s]), int'(mst[s] == 1));
        check(int'(rcfg_task[s*IW +: IW]) == mown[s], "R9 target vs model",
              int'(rcfg_task[s*IW +: IW]), mown[s]);
      end
      for (int i = 0; i < N; i++) begin
        bit eg;
        eg = 1'b0;
        for (int s = 0; s < M; s++) if (mst[s] == 2 && mown[s] == i) eg = acc_req[i];
        check(acc_gnt[i] == eg, "R7 grant vs model", int'(acc_gnt[i]), int'(eg));
      end
    end
  end

  task automatic complete(input int t, input int v);
    @(negedge clk);
    done_vld[t] = 1'b1;
    done_sav[t*SW +: SW] = SW'(v);
    @(negedge clk);
    done_vld = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_done(input int s);
    @(negedge clk);
    rcfg_done[s] = 1'b1;
    @(negedge clk);
    rcfg_done[s] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    check(rcfg_req == '0, "R11 no request after reset", int'(rcfg_req), 0);
    check(acc_gnt == '0, "R11 no grant after reset", int'(acc_gnt), 0);

    // R5 boundary: gap equal to threshold does not move
    complete(1, 10);
    check(rcfg_req == '0, "R5 gap equal to threshold", int'(rcfg_req), 0);
    // R1 savings from software run push task1 over the threshold
    complete(1, 1);
    check(rcfg_req[0] == 1'b1, "R1 accumulated savings trigger load", int'(rcfg_req[0]), 1);
    check(int'(rcfg_task[IW-1:0]) == 1, "R9 target task", int'(rcfg_task[IW-1:0]), 1);
    check(acc_gnt == '0, "R8 no grant while loading", int'(acc_gnt), 0);
    repeat (10) @(negedge clk);
    check(rcfg_req[0] == 1'b1, "R9 request held until done", int'(rcfg_req[0]), 1);
    pulse_done(0);
    check(acc_gnt == 3'b010, "R8 grant after done", int'(acc_gnt), 2);
    check(rcfg_req == '0, "R9 request drops after done", int'(rcfg_req), 0);

    // R2 clipping and R4 tie order: both clip to 20, tie keeps owner
    complete(1, 200);
    complete(2, 255);
    check(rcfg_req == '0, "R2 R4 clipped tie causes no move", int'(rcfg_req), 0);
    check(acc_gnt == 3'b010, "R4 owner keeps grant", int'(acc_gnt), 2);

    // R6 busy owner blocks the move
    busy[1] = 1'b1;
    complete(0, 15);
    check(rcfg_req == '0, "R6 busy owner skips move", int'(rcfg_req), 0);
    check(acc_gnt == 3'b010, "R6 busy owner keeps grant", int'(acc_gnt), 2);
    @(negedge clk);
    busy[1] = 1'b0;
    @(negedge clk);
    check(rcfg_req[0] == 1'b1, "R6 move taken after busy falls", int'(rcfg_req[0]), 1);
    check(int'(rcfg_task[IW-1:0]) == 0, "R6 new target", int'(rcfg_task[IW-1:0]), 0);
    check(acc_gnt[1] == 1'b0, "R7 old owner loses grant", int'(acc_gnt[1]), 0);
    pulse_done(0);
    check(acc_gnt == 3'b001, "R8 new owner granted", int'(acc_gnt), 1);

    // R3 renormalisation lets task2 overtake with a gap of 11
    complete(2, 12);
    check(rcfg_req == '0, "R3 first renormalised update", int'(rcfg_req), 0);
    complete(2, 14);
    check(rcfg_req[0] == 1'b1 && int'(rcfg_task[IW-1:0]) == 2, "R3 move after offset",
          int'(rcfg_task[IW-1:0]), 2);
    pulse_done(0);

    // R10 simultaneous completions applied in index order
    @(negedge clk);
    done_vld = 3'b011;
    done_sav[0*SW +: SW] = SW'(5);
    done_sav[1*SW +: SW] = SW'(20);
    @(negedge clk);
    done_vld = '0;
    @(negedge clk);
    check(rcfg_req == '0, "R10 no decision before queue drains", int'(rcfg_req), 0);
    repeat (4) @(negedge clk);
    check(rcfg_req[0] == 1'b1 && int'(rcfg_task[IW-1:0]) == 1, "R10 index-order result",
          int'(rcfg_task[IW-1:0]), 1);
    pulse_done(0);

    // sweep: random completions, busy, access requests and load completions
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        done_vld[i] = ($urandom % 8) == 0;
        done_sav[i*SW +: SW] = SW'($urandom % 24);
        if (($urandom % 12) == 0) busy[i] = ~busy[i];
        acc_req[i] = ($urandom % 4) != 0;
      end
      for (int s = 0; s < M; s++) rcfg_done[s] = (mst[s] == 1) && (($urandom % 6) == 0);
    end
    @(negedge clk);
    done_vld = '0;
    rcfg_done = '0;
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule